// File: doc/BRIEF.md
# Leap-Ahead LFSR Gaussian Noise Generator

This block turns a 33-bit maximal-length linear feedback shift register into a source of approximately normally distributed integers. Each enabled clock, the register jumps forward a parameterised number of single shifts in one step. The jump is a combinational XOR matrix that is worked out at elaboration, in the same way as a one-clock CRC update. The low 16 bits of the register are the uniform word for that cycle.

A block accumulator adds sixteen consecutive uniform words. By the central limit theorem the total is close to bell-shaped. When a group is complete, the block presents the total for one cycle, both as an unsigned sum and centred on zero. With the enable held high it gives one sample every sixteen clocks. A seed port restarts the register and the accumulator, so any run can be reproduced exactly.

Top module: `lfsr_gauss_gen`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, valid_o is 0 and word_o is 16'hA5A5. The state is reset to 33'h0_5A5A_A5A5.
- R2: word_o is bits 15:0 of the 33-bit state. One single shift maps state s to {s[31:0], s[32]^s[19]}, which is the polynomial x^33+x^20+1. Each clock with en_i high and load_i low applies LEAP single shifts.
- R3: With en_i and load_i both low, the state and the partial sum do not change, word_o is stable and valid_o stays low.
- R4: load_i has priority over en_i. It sets the state to seed_i and discards any partial sum. From the next cycle on, word_o equals seed_i[15:0].
- R5: A load with seed_i equal to zero sets the state to 33'h0_5A5A_A5A5 instead, so word_o becomes 16'hA5A5.
- R6: Counting from reset, from a load, or from the previous sample, the sixteenth enabled clock raises valid_o in the following cycle, for exactly one cycle. sample_o then holds the 20-bit sum of the sixteen words that word_o showed on those enabled clocks.
- R7: sample_c_o equals sample_o minus 524288 as 20-bit two's complement. sample_o never exceeds 16*65535.
- R8: LEAP is independent of the register length. Both the default of 16 and a value of 33 follow R2 exactly.
- R9: Over 1024 samples from a nonzero seed, the mean of sample_c_o stays within ±12000 of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load seed_i into the state and clear the partial sum |
| seed_i | input | 33 | Seed value; zero is replaced by the fixed constant |
| en_i | input | 1 | Advance the register and accumulate one word |
| word_o | output | 16 | Current uniform word (state bits 15:0) |
| valid_o | output | 1 | One-cycle strobe marking a finished sample |
| sample_o | output | 20 | Unsigned sum of sixteen words |
| sample_c_o | output | 20 | Signed sample_o minus 524288 |

## Verification
The checker tests properties on every cycle:
- a seed load shows on word_o one cycle later, with the zero-seed substitute where it applies;
- an idle cycle leaves word_o unchanged and raises no strobe;
- the valid strobe lasts one cycle and always follows an enabled cycle;
- a reported sum never exceeds its ceiling.

The bench covers what needs a reference sequence. It compares every word, at both LEAP=16 and LEAP=33, against a software model that applies single shifts one at a time. It checks each sum against words it collected itself, checks that a mid-group load discards the partial sum, and checks that the long-run mean is near zero.

// File: rtl/gauss_pkg.sv
package gauss_pkg;
  localparam int unsigned LFSR_W = 33;
  localparam int unsigned TAP_HI = 32;
  localparam int unsigned TAP_LO = 19;
  localparam logic [LFSR_W-1:0] ZERO_SUB = 33'h0_5A5A_A5A5;

  typedef logic [LFSR_W-1:0] lfsr_t;
  typedef logic [LFSR_W-1:0][LFSR_W-1:0] leap_mat_t;

  // row i: mask of current-state bits whose XOR gives next bit i after `steps` shifts
  function automatic leap_mat_t leap_matrix(int unsigned steps);
    leap_mat_t m;
    lfsr_t     fb;
    for (int i = 0; i < LFSR_W; i++) begin
      m[i]    = '0;
      m[i][i] = 1'b1;
    end
    for (int unsigned s = 0; s < steps; s++) begin
      fb = m[TAP_HI] ^ m[TAP_LO];
      for (int i = LFSR_W - 1; i > 0; i--) m[i] = m[i-1];
      m[0] = fb;
    end
    return m;
  endfunction
endpackage

// File: rtl/gauss_lfsr_leap.sv
module gauss_lfsr_leap
  import gauss_pkg::*;
#(
  parameter int unsigned LEAP   = 16,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  lfsr_t             seed_i,
  input  logic              adv_i,
  output logic [WORD_W-1:0] word_o
);
  localparam leap_mat_t MAT = leap_matrix(LEAP);

  lfsr_t state_q, state_nxt, seed_eff;

  for (genvar i = 0; i < LFSR_W; i++) begin : g_row
    assign state_nxt[i] = ^(state_q & MAT[i]);
  end

  assign seed_eff = (seed_i == '0) ? ZERO_SUB : seed_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= ZERO_SUB;
    else if (load_i) state_q <= seed_eff;
    else if (adv_i)  state_q <= state_nxt;
  end

  assign word_o = state_q[WORD_W-1:0];
endmodule

// File: rtl/gauss_block_acc.sv
module gauss_block_acc #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned N_SUM  = 16,
  parameter int unsigned SUM_W  = WORD_W + $clog2(N_SUM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              add_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              valid_o,
  output logic [SUM_W-1:0]  sum_o
);
  localparam int unsigned CNT_W = $clog2(N_SUM);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_SUM - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] acc_q, acc_add;
  logic             valid_q;

  assign acc_add = acc_q + SUM_W'(word_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      sum_o   <= '0;
      valid_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      valid_q <= 1'b0;
    end else if (add_i) begin
      if (cnt_q == LAST) begin
        cnt_q   <= '0;
        acc_q   <= '0;
        sum_o   <= acc_add;
        valid_q <= 1'b1;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
        acc_q   <= acc_add;
        valid_q <= 1'b0;
      end
    end else begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/lfsr_gauss_gen.sv
module lfsr_gauss_gen
  import gauss_pkg::*;
#(
  parameter int unsigned LEAP   = 16,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned N_SUM  = 16,
  localparam int unsigned SUM_W = WORD_W + $clog2(N_SUM)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [LFSR_W-1:0]       seed_i,
  input  logic                    en_i,
  output logic [WORD_W-1:0]       word_o,
  output logic                    valid_o,
  output logic [SUM_W-1:0]        sample_o,
  output logic signed [SUM_W-1:0] sample_c_o
);
  localparam logic [SUM_W-1:0] MID = SUM_W'(N_SUM) << (WORD_W - 1);

  logic adv;
  assign adv = en_i & ~load_i;

  gauss_lfsr_leap #(.LEAP(LEAP), .WORD_W(WORD_W)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .seed_i (seed_i),
    .adv_i  (adv),
    .word_o (word_o)
  );

  gauss_block_acc #(.WORD_W(WORD_W), .N_SUM(N_SUM), .SUM_W(SUM_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (load_i),
    .add_i   (adv),
    .word_i  (word_o),
    .valid_o (valid_o),
    .sum_o   (sample_o)
  );

  assign sample_c_o = $signed(sample_o - MID);
endmodule

// File: rtl/gauss_chk.sv
module gauss_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned N_SUM  = 16,
  parameter int unsigned SUM_W  = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [32:0]       seed_i,
  input logic              en_i,
  input logic [WORD_W-1:0] word_o,
  input logic              valid_o,
  input logic [SUM_W-1:0]  sample_o
);
  localparam logic [SUM_W-1:0] MAXSUM = SUM_W'(N_SUM * ((1 << WORD_W) - 1));

  a_r4_seed_shows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && seed_i != '0) |=> word_o == $past(seed_i[WORD_W-1:0]));

  a_r5_zero_subst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && seed_i == '0) |=> word_o == WORD_W'(33'h0_5A5A_A5A5));

  a_r3_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !en_i) |=> ($stable(word_o) && !valid_o));

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r6_after_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(en_i && !load_i));

  a_r7_sum_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> sample_o <= MAXSUM);
endmodule

bind lfsr_gauss_gen gauss_chk #(.WORD_W(WORD_W), .N_SUM(N_SUM), .SUM_W(SUM_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .load_i   (load_i),
  .seed_i   (seed_i),
  .en_i     (en_i),
  .word_o   (word_o),
  .valid_o  (valid_o),
  .sample_o (sample_o)
);

// File: tb/sim_lfsr_gauss_gen.sv
`timescale 1ns/1ps
module sim_lfsr_gauss_gen;
  localparam logic [32:0] FIX = 33'h0_5A5A_A5A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [32:0] seed = '0;
  logic        en = 1'b0;
  logic [15:0] word0, word1;
  logic        valid0, valid1;
  logic [19:0] samp0, samp1;
  logic signed [19:0] samc0, samc1;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic [32:0] m0, m1;
  logic [19:0] acc0, acc1, exp0, exp1;
  int          cnt;
  bit          expv;
  longint      csum;
  int          nsamp;

  always #10 clk = ~clk;

  lfsr_gauss_gen #(.LEAP(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .seed_i(seed), .en_i(en),
    .word_o(word0), .valid_o(valid0), .sample_o(samp0), .sample_c_o(samc0)
  );

  lfsr_gauss_gen #(.LEAP(33)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .seed_i(seed), .en_i(en),
    .word_o(word1), .valid_o(valid1), .sample_o(samp1), .sample_c_o(samc1)
  );

  function automatic logic [32:0] sstep(logic [32:0] s, int n);
    for (int k = 0; k < n; k++) s = {s[31:0], s[32] ^ s[19]};
    return s;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint expv_);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv_);
    end
  endtask

  task automatic model_reset();
    m0 = FIX; m1 = FIX; acc0 = 0; acc1 = 0; cnt = 0; expv = 0;
  endtask

  // drive one cycle at negedge, update model, check after the edge
  task automatic cyc(bit e, bit l, logic [32:0] sd);
    en = e; load = l; seed = sd;
    expv = 0;
    if (l) begin
      m0 = (sd == 0) ? FIX : sd; m1 = m0;
      acc0 = 0; acc1 = 0; cnt = 0;
    end else if (e) begin
      if (cnt == 15) begin
        exp0 = acc0 + 20'(m0[15:0]); exp1 = acc1 + 20'(m1[15:0]);
        acc0 = 0; acc1 = 0; cnt = 0; expv = 1;
      end else begin
        acc0 += 20'(m0[15:0]); acc1 += 20'(m1[15:0]); cnt++;
      end
      m0 = sstep(m0, 16); m1 = sstep(m1, 33);
    end
    @(posedge clk);
    @(negedge clk);
    chk(word0 == m0[15:0], "R2 word LEAP=16", word0, m0[15:0]);
    chk(word1 == m1[15:0], "R8 word LEAP=33", word1, m1[15:0]);
    chk(valid0 == expv, "R6 valid strobe", valid0, expv);
    if (expv) begin
      chk(samp0 == exp0, "R6 sum LEAP=16", samp0, exp0);
      chk(samp1 == exp1, "R8 sum LEAP=33", samp1, exp1);
      chk(samc0 == $signed(exp0 - 20'd524288), "R7 centred", samc0, $signed(exp0 - 20'd524288));
      chk(samp0 <= 20'd1048560, "R7 ceiling", samp0, 1048560);
      csum += longint'(samc0);
      nsamp++;
    end
  endtask

  task automatic t_reset();
    rst_n = 0; en = 0; load = 0; seed = '0;
    repeat (3) @(negedge clk);
    chk(valid0 == 0, "R1 valid in reset", valid0, 0);
    chk(word0 == 16'hA5A5, "R1 word in reset", word0, 16'hA5A5);
    rst_n = 1;
    model_reset();
    @(negedge clk);
    chk(word0 == 16'hA5A5 && valid0 == 0, "R1 after release", word0, 16'hA5A5);
    for (int i = 0; i < 20; i++) cyc(1, 0, '0);  // sample from reset state
  endtask

  task automatic t_seed_walk();
    cyc(0, 1, 33'h1_2345_6789);
    chk(word0 == 16'h6789, "R4 seed word", word0, 16'h6789);
    for (int i = 0; i < 48; i++) cyc(1, 0, '0);
  endtask

  task automatic t_idle_hold();
    logic [15:0] w;
    cyc(0, 1, 33'h0_0F0F_1234);
    for (int i = 0; i < 7; i++) cyc(1, 0, '0);
    w = word0;
    for (int i = 0; i < 10; i++) cyc(0, 0, '0);
    chk(word0 == w, "R3 hold word", word0, w);
    for (int i = 0; i < 9; i++) cyc(1, 0, '0);  // group completes after gap
  endtask

  task automatic t_load_priority();
    cyc(0, 1, 33'h1_0000_BEEF);
    for (int i = 0; i < 10; i++) cyc(1, 0, '0);
    cyc(1, 1, 33'h0_7777_4321);  // load with en high, partial sum discarded
    chk(word0 == 16'h4321, "R4 load priority", word0, 16'h4321);
    for (int i = 0; i < 16; i++) cyc(1, 0, '0);
  endtask

  task automatic t_zero_seed();
    cyc(1, 1, '0);
    chk(word0 == 16'hA5A5, "R5 zero seed substitute", word0, 16'hA5A5);
    for (int i = 0; i < 32; i++) cyc(1, 0, '0);
    chk(word0 != 0 || word1 != 0, "R5 no lockup", word0, 1);
  endtask

  task automatic t_stats();
    longint mean;
    csum = 0; nsamp = 0;
    cyc(0, 1, 33'h1_DEAD_BEEF);
    for (int i = 0; i < 1024 * 16; i++) cyc(1, 0, '0);
    chk(nsamp == 1024, "R9 sample count", nsamp, 1024);
    mean = csum / 1024;
    chk(mean > -12000 && mean < 12000, "R9 mean near zero", mean, 0);
  endtask

  initial begin
    t_reset();
    t_seed_walk();
    t_idle_hold();
    t_load_priority();
    t_zero_seed();
    t_stats();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule